// File: doc/BRIEF.md
# Scatter/Gather Descriptor Table Walker

This block moves a requested number of bytes between an internal sector buffer and host memory by following a table of region descriptors in memory. Each descriptor takes 8 bytes. The first 32-bit little-endian word holds the physical address of a region. The second word holds the region size, plus a flag that marks the end of the table. A pulse on `start` gives the block the table base, the byte count and the direction. The block then fetches descriptors one word at a time over a simple read port. It cuts each region into requests for an external data mover, and ends with a one-cycle `done` or `exhausted` pulse.

The walk is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_DECIDE`: chooses the next step.
- `ST_RD_ADDR` and `ST_WT_ADDR`: request and await the address word.
- `ST_RD_SIZE` and `ST_WT_SIZE`: request and await the size word.
- `ST_MOVE`: offers one chunk to the mover.
- `ST_DONE` and `ST_EXHAUST`: one-cycle end states.

The transitions are:
- `start` in `ST_IDLE` leads to `ST_DECIDE`.
- From `ST_DECIDE`, the walk goes to `ST_DONE` when no bytes remain. It goes to `ST_MOVE` while the current region still holds bytes. It goes to `ST_EXHAUST` when the region is empty and either the end flag was seen or the fail-safe window is used up. Otherwise it goes to `ST_RD_ADDR`.
- `ST_RD_ADDR` leads to `ST_WT_ADDR` on grant, then to `ST_RD_SIZE` on response.
- `ST_RD_SIZE` leads to `ST_WT_SIZE` on grant, then back to `ST_DECIDE` on response.
- `ST_MOVE` returns to `ST_DECIDE` on mover acceptance.
- `ST_DONE` and `ST_EXHAUST` return to `ST_IDLE`.

Top module: `prd_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `mv_valid`, `done` and `exhausted` are all low.
- R2: A descriptor is fetched as two reads: the address word at the fetch pointer, then the size word at pointer+4. Only one read is in flight at a time. A request holds its address until it is granted. No mover request is made while a fetch is pending.
- R3: The region length is size word bits 15:1 times two, so bit 0 is ignored. A length field of zero means 65536 bytes.
- R4: Bit 31 of the size word marks the final descriptor. Once that region is used up, no further descriptor is fetched.
- R5: The fetch pointer advances by 8 per descriptor. No fetch is issued at an offset of 4096 or more from the table base, so at most 512 descriptors are read per job.
- R6: Each mover request has a length equal to the smaller of the bytes still requested and the bytes left in the region. Its address is the region address plus the bytes already taken from that region. The length is never zero and never above 65536.
- R7: When the requested count has been fully handed to the mover, `done` pulses for one cycle and the block returns to idle. A count of zero gives `done` without any fetch.
- R8: When the table ends (end flag or fail-safe) before the count has been handed over, `exhausted` pulses for one cycle instead of `done`.
- R9: `start` in idle loads the fetch pointer from `start_base` with bits 1:0 cleared. `start` while busy is ignored.
- R10: `mv_write` equals the `start_write` value captured at the start of the job.
- R11: While `mv_valid` is high and `mv_ready` is low, `mv_valid`, `mv_addr`, `mv_len` and `mv_write` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (taken only when idle) |
| start_base | input | AW | Descriptor table base address |
| start_count | input | CW | Total bytes to move |
| start_write | input | 1 | Direction: 1 = buffer to memory |
| busy | output | 1 | A job is in progress |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Descriptor word address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| mv_valid | output | 1 | Mover request valid |
| mv_addr | output | AW | Host address of the chunk |
| mv_len | output | 17 | Chunk length in bytes |
| mv_write | output | 1 | Chunk direction |
| mv_ready | input | 1 | Mover accepts the request |
| done | output | 1 | Job completed (one cycle) |
| exhausted | output | 1 | Table ended before count moved (one cycle) |

## Verification
On every cycle, the assertions check the handshake rules:
- fetch requests hold while ungranted, and mover requests hold while not ready;
- a fetch and a mover request are never raised together;
- fetch addresses are word aligned and stay inside the 4096-byte window;
- chunk lengths are legal, and the pointer reloads and steps correctly;
- `done` and `exhausted` are exclusive, and each is followed by idle.

Only the bench scenarios can show that the walk is correct as a whole. They compare the exact chunk sequence, the fetch address sequence and the ending against a reference walk. This covers the zero-length region, the odd size bit and the 512-descriptor fail-safe. It also covers early completion inside a region, and that a start during a job is ignored.

// File: rtl/prd_walk_pkg.sv
`timescale 1ns/1ps
package prd_walk_pkg;

    localparam int REGION_W   = 17;      // holds 1..65536
    localparam int DESC_BYTES = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_RD_ADDR,
        ST_WT_ADDR,
        ST_RD_SIZE,
        ST_WT_SIZE,
        ST_MOVE,
        ST_DONE,
        ST_EXHAUST
    } walk_state_e;

endpackage

// File: rtl/prd_len_decode.sv
`timescale 1ns/1ps
module prd_len_decode
    import prd_walk_pkg::*;
(
    input  logic [14:0]          len_field,   // size word bits 15:1
    output logic [REGION_W-1:0]  region_len
);
    always_comb begin
        if (len_field == '0) begin
            region_len = REGION_W'(1) << 16;
        end else begin
            region_len = {1'b0, len_field, 1'b0};
        end
    end
endmodule

// File: rtl/prd_chunk_sel.sv
`timescale 1ns/1ps
module prd_chunk_sel
    import prd_walk_pkg::*;
#(
    parameter int CW = 20
) (
    input  logic [CW-1:0]        remain,
    input  logic [REGION_W-1:0]  region_left,
    output logic [REGION_W-1:0]  chunk
);
    localparam int W = (CW > REGION_W) ? CW : REGION_W;

    logic [W-1:0] rem_w;
    logic [W-1:0] reg_w;

    always_comb begin
        rem_w = W'(remain);
        reg_w = W'(region_left);
        if (rem_w < reg_w) begin
            chunk = REGION_W'(rem_w);
        end else begin
            chunk = region_left;
        end
    end
endmodule

// File: rtl/prd_fetch_ptr.sv
`timescale 1ns/1ps
module prd_fetch_ptr
    import prd_walk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LIMIT = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_base,
    input  logic          advance,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] ptr_q,
    output logic          at_limit
);
    localparam logic [AW-1:0] LIMIT_A = AW'(LIMIT);
    localparam logic [AW-1:0] STEP_A  = AW'(DESC_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (load) begin
            base_q <= {load_base[AW-1:2], 2'b00};
            ptr_q  <= {load_base[AW-1:2], 2'b00};
        end else if (advance) begin
            ptr_q  <= ptr_q + STEP_A;
        end
    end

    assign at_limit = (ptr_q - base_q) >= LIMIT_A;

    // R9: a load makes the pointer equal the base
    p_load_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr_q == base_q));
    // R5: pointer steps by one descriptor
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (ptr_q == $past(ptr_q) + STEP_A));
endmodule

// File: rtl/prd_walker.sv
`timescale 1ns/1ps
module prd_walker
    import prd_walk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 20,
    parameter int LIMIT = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        start_base,
    input  logic [CW-1:0]        start_count,
    input  logic                 start_write,
    output logic                 busy,
    output logic                 mem_req,
    output logic [AW-1:0]        mem_addr,
    input  logic                 mem_gnt,
    input  logic                 mem_rsp_valid,
    input  logic [31:0]          mem_rsp_data,
    output logic                 mv_valid,
    output logic [AW-1:0]        mv_addr,
    output logic [REGION_W-1:0]  mv_len,
    output logic                 mv_write,
    input  logic                 mv_ready,
    output logic                 done,
    output logic                 exhausted
);
    localparam logic [AW-1:0] WORD_A  = AW'(4);
    localparam logic [AW-1:0] LIMIT_A = AW'(LIMIT);

    walk_state_e state_q, state_d;

    logic [CW-1:0]        remain_q;
    logic [AW-1:0]        raddr_q;
    logic [REGION_W-1:0]  rlen_q;
    logic                 last_q;
    logic                 dir_q;

    logic [AW-1:0]        base_q, ptr_q;
    logic                 at_limit;
    logic                 ptr_load, ptr_adv;
    logic [REGION_W-1:0]  dec_len;
    logic [REGION_W-1:0]  chunk;
    logic                 unused_bits;

    assign unused_bits = ^{mem_rsp_data[30:16], mem_rsp_data[0]};

    assign ptr_load = (state_q == ST_IDLE) && start;
    assign ptr_adv  = (state_q == ST_WT_SIZE) && mem_rsp_valid;

    prd_fetch_ptr #(.AW(AW), .LIMIT(LIMIT)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_base (start_base),
        .advance   (ptr_adv),
        .base_q    (base_q),
        .ptr_q     (ptr_q),
        .at_limit  (at_limit)
    );

    prd_len_decode u_dec (
        .len_field  (mem_rsp_data[15:1]),
        .region_len (dec_len)
    );

    prd_chunk_sel #(.CW(CW)) u_chunk (
        .remain      (remain_q),
        .region_left (rlen_q),
        .chunk       (chunk)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (remain_q == '0)           state_d = ST_DONE;
                else if (rlen_q != '0)        state_d = ST_MOVE;
                else if (last_q || at_limit)  state_d = ST_EXHAUST;
                else                          state_d = ST_RD_ADDR;
            end
            ST_RD_ADDR: if (mem_gnt)       state_d = ST_WT_ADDR;
            ST_WT_ADDR: if (mem_rsp_valid) state_d = ST_RD_SIZE;
            ST_RD_SIZE: if (mem_gnt)       state_d = ST_WT_SIZE;
            ST_WT_SIZE: if (mem_rsp_valid) state_d = ST_DECIDE;
            ST_MOVE:    if (mv_ready)      state_d = ST_DECIDE;
            ST_DONE:    state_d = ST_IDLE;
            ST_EXHAUST: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = (state_q == ST_RD_ADDR) || (state_q == ST_RD_SIZE);
        mem_addr  = (state_q == ST_RD_SIZE) ? (ptr_q + WORD_A) : ptr_q;
        mv_valid  = (state_q == ST_MOVE);
        mv_addr   = raddr_q;
        mv_len    = chunk;
        mv_write  = dir_q;
        done      = (state_q == ST_DONE);
        exhausted = (state_q == ST_EXHAUST);
    end

    // job datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            raddr_q  <= '0;
            rlen_q   <= '0;
            last_q   <= 1'b0;
            dir_q    <= 1'b0;
        end else begin
            if (ptr_load) begin
                remain_q <= start_count;
                rlen_q   <= '0;
                last_q   <= 1'b0;
                dir_q    <= start_write;
            end
            if ((state_q == ST_WT_ADDR) && mem_rsp_valid) begin
                raddr_q <= mem_rsp_data[AW-1:0];
            end
            if (ptr_adv) begin
                rlen_q <= dec_len;
                last_q <= mem_rsp_data[31];
            end
            if ((state_q == ST_MOVE) && mv_ready) begin
                raddr_q  <= raddr_q + AW'(chunk);
                rlen_q   <= rlen_q - chunk;
                remain_q <= remain_q - CW'(chunk);
            end
        end
    end

    // R2: fetch request holds until granted
    p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
    // R2: fetch and move never overlap
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mv_valid));
    // R9: fetch addresses word aligned
    p_mem_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R5: fetches stay inside the fail-safe window
    p_fetch_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - base_q) < LIMIT_A));
    // R6: chunk length legal
    p_chunk_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> ((mv_len != '0) && (mv_len <= (REGION_W'(1) << 16))));
    // R11: mover request held while not ready
    p_mv_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_addr)
                                     && $stable(mv_len) && $stable(mv_write)));
    // R7 / R8: endings exclusive and followed by idle
    p_end_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exhausted));
    p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || exhausted) |=> !busy);
endmodule

// File: tb/prd_walker_bench.sv
`timescale 1ns/1ps
module prd_walker_bench;
    localparam int AW = 32;
    localparam int CW = 20;
    localparam int NT = 600;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start, start_write, busy, mem_req, mem_gnt, mem_rsp_valid;
    logic [AW-1:0] start_base, mem_addr, mv_addr;
    logic [CW-1:0] start_count;
    logic [31:0] mem_rsp_data;
    logic mv_valid, mv_write, mv_ready, done, exhausted;
    logic [16:0] mv_len;

    prd_walker #(.AW(AW), .CW(CW), .LIMIT(4096)) u_prd_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
        .start_count(start_count), .start_write(start_write), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mv_valid(mv_valid), .mv_addr(mv_addr), .mv_len(mv_len),
        .mv_write(mv_write), .mv_ready(mv_ready), .done(done),
        .exhausted(exhausted)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] tbl_addr [0:NT-1];
    logic [31:0] tbl_size [0:NT-1];
    logic [31:0] tb_base;

    int          fetch_n;
    logic [31:0] fetch_log [0:2*NT-1];
    int          got_n;
    logic [31:0] got_addr [0:NT-1];
    int          got_len  [0:NT-1];
    logic        got_wr   [0:NT-1];

    int          e_n, e_fetch;
    bit          e_exh;
    logic [31:0] e_addr [0:NT-1];
    int          e_len  [0:NT-1];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] off;
        int idx;
        off = a - tb_base;
        idx = int'(off >> 3);
        if (off >= 32'(8 * NT)) return 32'h0;
        return off[2] ? tbl_size[idx] : tbl_addr[idx];
    endfunction

    // reference walk computed from the requirements
    task automatic ref_walk(input logic [31:0] base, input int cnt);
        logic [31:0] fptr, ra, sw;
        int rem, rlen, ch, idx;
        bit lst;
        fptr = base; rem = cnt; rlen = 0; lst = 0; ra = 0;
        e_n = 0; e_fetch = 0; e_exh = 0;
        while (rem > 0) begin
            if (rlen == 0) begin
                if (lst || (fptr - base) >= 32'd4096) begin
                    e_exh = 1;
                    break;
                end
                idx = int'((fptr - base) >> 3);
                ra = tbl_addr[idx];
                sw = tbl_size[idx];
                fptr += 8;
                e_fetch += 2;
                rlen = int'(sw & 32'hFFFE);
                if (rlen == 0) rlen = 65536;
                lst = sw[31];
            end
            ch = (rem < rlen) ? rem : rlen;
            if (e_n < NT) begin
                e_addr[e_n] = ra;
                e_len[e_n]  = ch;
            end
            e_n++;
            ra += 32'(ch); rlen -= ch; rem -= ch;
        end
    endtask

    // descriptor memory responder
    initial begin
        logic [31:0] a;
        mem_gnt = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req && ($urandom_range(0, 2) != 0)) begin
                a = mem_addr;
                mem_gnt = 1;
                @(negedge clk);
                mem_gnt = 0;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                if (fetch_n < 2 * NT) fetch_log[fetch_n] = a;
                fetch_n++;
                mem_rsp_data = mem_word(a);
                mem_rsp_valid = 1;
                @(negedge clk);
                mem_rsp_valid = 0;
            end
        end
    end

    // data mover responder
    initial begin
        logic [31:0] ca;
        int cl;
        logic cw;
        mv_ready = 0;
        forever begin
            @(negedge clk);
            if (mv_ready) begin
                if (got_n < NT) begin
                    got_addr[got_n] = ca; got_len[got_n] = cl; got_wr[got_n] = cw;
                end
                got_n++;
            end
            mv_ready = 0;
            if (rst_n && mv_valid && ($urandom_range(0, 3) != 0)) begin
                mv_ready = 1;
                ca = mv_addr; cl = int'(mv_len); cw = mv_write;
            end
        end
    end

    task automatic run_job(input logic [31:0] base_in, input int cnt,
                           input bit wr, input string tag, input bit poke);
        bit saw_done, saw_exh;
        logic [31:0] b;
        b = {base_in[31:2], 2'b00};
        tb_base = b;
        ref_walk(b, cnt);
        fetch_n = 0; got_n = 0;
        saw_done = 0; saw_exh = 0;
        @(negedge clk);
        start = 1; start_base = base_in; start_count = CW'(cnt); start_write = wr;
        @(negedge clk);
        start = 0;
        if (poke) begin
            @(negedge clk);
            // R9: start while busy must be ignored
            start = 1; start_base = base_in + 32'h100; start_count = 3; start_write = ~wr;
            @(negedge clk);
            start = 0;
        end
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (done || exhausted) begin
                saw_done = done; saw_exh = exhausted;
                break;
            end
        end
        repeat (3) @(negedge clk);
        if (e_exh) chk(saw_exh && !saw_done, "R8", {tag, " exhausted"}, saw_exh, 1);
        else       chk(saw_done && !saw_exh, "R7", {tag, " done"}, saw_done, 1);
        chk(!busy, "R7", {tag, " idle after end"}, busy, 0);
        chk(got_n == e_n, "R6", {tag, " chunk count"}, got_n, e_n);
        for (int i = 0; i < e_n && i < got_n && i < NT; i++) begin
            chk(got_addr[i] == e_addr[i], "R6", {tag, " chunk addr"}, got_addr[i], e_addr[i]);
            chk(got_len[i] == e_len[i], "R6", {tag, " chunk len"}, got_len[i], e_len[i]);
            chk(got_wr[i] == wr, "R10", {tag, " chunk dir"}, got_wr[i], wr);
        end
        chk(fetch_n == e_fetch, "R5", {tag, " fetch count"}, fetch_n, e_fetch);
        for (int i = 0; i < fetch_n && i < 2 * NT; i++) begin
            chk(fetch_log[i] == b + 32'(4 * i), "R2", {tag, " fetch addr"},
                fetch_log[i], b + 32'(4 * i));
        end
    endtask

    task automatic clear_tbl();
        for (int i = 0; i < NT; i++) begin
            tbl_addr[i] = 32'h0; tbl_size[i] = 32'h8000_0002;
        end
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
            begin
                void'($urandom(32'd20240611));
                rst_n = 0; start = 0; start_base = 0; start_count = 0; start_write = 0;
                fetch_n = 0; got_n = 0; tb_base = 0;
                clear_tbl();
                repeat (4) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                // R1: reset state
                chk(!busy && !mem_req && !mv_valid && !done && !exhausted, "R1",
                    "idle after reset", {busy, mem_req, mv_valid, done, exhausted}, 0);

                // basic three-region table, bit 0 of the middle size ignored (R3), last flag (R4)
                clear_tbl();
                tbl_addr[0] = 32'h0000_1000; tbl_size[0] = 32'h0000_0010;
                tbl_addr[1] = 32'h0000_2000; tbl_size[1] = 32'h0000_0021;
                tbl_addr[2] = 32'h0000_3000; tbl_size[2] = 32'h8000_0008;
                run_job(32'h4000_0100, 32'h38, 1'b1, "R3 exact", 0);
                run_job(32'h4000_0100, 32'h20, 1'b0, "R7 early", 0);
                run_job(32'h4000_0100, 32'h100, 1'b1, "R4 past last", 0);
                // R9: unaligned base, plus a start pulse while busy
                run_job(32'h0050_0003, 32'h30, 1'b0, "R9 align+poke", 1);
                // R7: zero count, no fetch
                run_job(32'h4000_0100, 0, 1'b1, "R7 zero", 0);

                // R3: zero length field means 65536
                clear_tbl();
                tbl_addr[0] = 32'h1000_0000; tbl_size[0] = 32'h0000_0001;
                tbl_addr[1] = 32'h2000_0000; tbl_size[1] = 32'h8000_0010;
                run_job(32'h0000_8000, 65540, 1'b1, "R3 64k", 0);

                // R5: fail-safe after 512 descriptors without a last flag
                clear_tbl();
                for (int i = 0; i < NT; i++) begin
                    tbl_addr[i] = 32'h0100_0000 + 32'(i * 16);
                    tbl_size[i] = 32'h0000_0002;
                end
                run_job(32'h0001_0000, 5000, 1'b0, "R5 failsafe", 0);

                // constrained random jobs (R6, R10, R11 via random mover stalls)
                for (int j = 0; j < 25; j++) begin
                    int n;
                    clear_tbl();
                    n = $urandom_range(1, 6);
                    for (int i = 0; i < n; i++) begin
                        tbl_addr[i] = $urandom() & 32'hFFFF_FFF0;
                        if ($urandom_range(0, 9) == 0) tbl_size[i] = 32'h0;
                        else tbl_size[i] = 32'($urandom_range(0, 60));
                        if (i == n - 1 || $urandom_range(0, 7) == 0)
                            tbl_size[i] = tbl_size[i] | 32'h8000_0000;
                    end
                    run_job($urandom() & 32'hFFFF_FFF8, $urandom_range(0, 200),
                            1'($urandom_range(0, 1)), "R6 random", 0);
                end
            end
        join_any
        if (timed_out) begin
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule